// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a stereo PCM stream carried on a bit clock, a frame clock and a serial data line, all sampled in a faster system clock domain, and turns it into signed 24-bit left/right sample pairs. One 2-bit format input picks the framing convention: right-justified, I2S, left-justified or a pulse-framed DSP style. A second 2-bit input sets the word length used in right-justified framing. Samples arrive two's complement, MSB first, with the left word ahead of the right word in every frame.

The three serial inputs pass through synchronisers. Bit-clock edges are then found in the system clock domain, so the bit clock may stop or run in bursts. A position counter advances only on capture edges and restarts at each framing edge. A word is closed when the next framing edge arrives, and a pair is released once the right word closes. The pair leaves on a valid/ready interface. The serial stream cannot be stalled, so back-pressure is handled this way: `out_valid_o` stays high and the data stays stable until a cycle with `out_ready_i` high, and a newer pair that completes before that replaces the held one. A per-channel zero flag reports long runs of silent samples.

Top module: `pcm_rx_top`

## Requirements
- R1: With format 2'b10 (left-justified), a high frame clock marks the left word. Data is taken on rising bit-clock edges, and the MSB is the bit taken at the first rising edge that sees the new frame-clock level.
- R2: With format 2'b01 (I2S), a low frame clock marks the left word. Data is taken on rising edges, and the MSB is taken one bit clock after the first edge that sees the new level.
- R3: With format 2'b00 (right-justified), a high frame clock marks left. Word-length code 00, 01 or 10 selects 24, 20 or 16 bits. Counting the edge that sees the transition as index 0, the first bit is taken at index 8, 12 or 16. The word is sign-extended to 24 bits.
- R4: With format 2'b11 (DSP), data is taken on falling bit-clock edges. The edge at which the frame clock is first seen high is a sync slot, and the MSB follows on the next falling edge. The first pulse after reset marks left, and later pulses alternate right, left and so on.
- R5: Outside right-justified framing, only the first 24 bits of a word are kept. A shorter word is placed MSB-aligned, with zeros below it.
- R6: A completed pair raises `out_valid_o`. It stays high with stable data until accepted with `out_ready_i` high, and drops the cycle after acceptance. A newer pair overwrites an unaccepted one.
- R7: A channel's zero flag is high once more than ZERO_FRAMES consecutive released pairs carried zero in that channel. It falls after a pair with a nonzero sample in that channel.
- R8: After reset, `out_valid_o` and both zero flags are low.
- R9: Holding the bit clock still at any point of a frame leaves the received words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Frame / channel-select clock |
| sdata_i | input | 1 | Serial audio data |
| fmt_i | input | 2 | Framing: 00 right-justified, 01 I2S, 10 left-justified, 11 DSP |
| rj_len_i | input | 2 | Right-justified length: 00 24, 01 20, 10 16 bits |
| out_valid_o | output | 1 | Sample pair available |
| out_ready_i | input | 1 | Consumer accepts the pair |
| out_left_o | output | 24 | Left sample, signed |
| out_right_o | output | 24 | Right sample, signed |
| zero_left_o | output | 1 | Left channel silent for more than ZERO_FRAMES pairs |
| zero_right_o | output | 1 | Right channel silent for more than ZERO_FRAMES pairs |

## Verification
Each framing mode is driven with asymmetric left/right words whose MSB and LSB differ. A swapped channel, a one-bit slip or a wrong capture edge therefore shows up as a different value. Word lengths of 16, 18, 20, 24 and 32 bits separate zero-filling, truncation and sign extension. Every frame carries a bit-clock pause to show that gating is harmless. A held-ready run and a zero-run of exactly the threshold and one past it pin down the handshake and the flag boundary.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  localparam int SAMPLE_W   = 24;
  localparam int HALF_SLOTS = 32;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_I2S = 2'b01,
    FMT_LJ  = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  // right-justified word width selected by the length code
  function automatic int rj_width(input logic [1:0] sel);
    case (sel)
      2'b01:   return 20;
      2'b10:   return 16;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic lrclk_i,
  input  logic sdata_i,
  output logic bclk_rise_o,
  output logic bclk_fall_o,
  output logic lr_o,
  output logic sd_o
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] pipe_q [STAGES];
  logic            bclk_d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
      bclk_d_q <= 1'b0;
    end else begin
      pipe_q[0] <= {bclk_i, lrclk_i, sdata_i};
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      bclk_d_q <= pipe_q[STAGES-1][2];
    end
  end

  assign bclk_rise_o =  pipe_q[STAGES-1][2] & ~bclk_d_q;
  assign bclk_fall_o = ~pipe_q[STAGES-1][2] &  bclk_d_q;
  assign lr_o        =  pipe_q[STAGES-1][1];
  assign sd_o        =  pipe_q[STAGES-1][0];
endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser
  import pcm_rx_pkg::*;
#(
  parameter int SW   = SAMPLE_W,
  parameter int HALF = HALF_SLOTS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fmt_i,
  input  logic [1:0]    rj_len_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          lr_i,
  input  logic          sd_i,
  output logic          pair_stb_o,
  output logic [SW-1:0] left_o,
  output logic [SW-1:0] right_o
);
  localparam int POS_W = $clog2(2*HALF);
  localparam int CNT_W = $clog2(SW+1);

  fmt_e fmt;
  assign fmt = fmt_e'(fmt_i);

  logic             lr_prev_q, live_q, cur_right_q, dsp_right_q, left_ok_q, stb_q;
  logic [POS_W-1:0] pos_q;
  logic [CNT_W-1:0] nbits_q;
  logic [SW-1:0]    acc_q, left_q, right_q;

  logic cap, frm, new_right, take;
  int   w_rj, start_i, limit_i;
  logic [SW-1:0] rj_val, lj_val, word_al;

  always_comb begin
    w_rj    = rj_width(rj_len_i);
    case (fmt)
      FMT_RJ:  start_i = HALF - w_rj;
      FMT_LJ:  start_i = 0;
      default: start_i = 1;
    endcase
    limit_i = (fmt == FMT_RJ) ? w_rj : SW;
  end

  assign cap       = (fmt == FMT_DSP) ? fall_i : rise_i;
  assign frm       = cap && ((fmt == FMT_DSP) ? (lr_i && !lr_prev_q) : (lr_i != lr_prev_q));
  assign new_right = (fmt == FMT_DSP) ? dsp_right_q : ((fmt == FMT_I2S) ? lr_i : !lr_i);
  assign take      = (int'(pos_q) >= start_i) && (int'(nbits_q) < limit_i);

  // alignment of the collected bits to a 24-bit sample
  always_comb begin
    for (int i = 0; i < SW; i++) rj_val[i] = (i < w_rj) ? acc_q[i] : acc_q[w_rj-1];
    lj_val  = acc_q << (SW - int'(nbits_q));
    word_al = (fmt == FMT_RJ) ? rj_val : lj_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_prev_q   <= 1'b0;
      live_q      <= 1'b0;
      cur_right_q <= 1'b0;
      dsp_right_q <= 1'b0;
      left_ok_q   <= 1'b0;
      stb_q       <= 1'b0;
      pos_q       <= '0;
      nbits_q     <= '0;
      acc_q       <= '0;
      left_q      <= '0;
      right_q     <= '0;
    end else begin
      stb_q <= 1'b0;
      if (cap) begin
        lr_prev_q <= lr_i;
        if (frm) begin
          if (live_q) begin
            if (cur_right_q) begin
              right_q   <= word_al;
              stb_q     <= left_ok_q;
              left_ok_q <= 1'b0;
            end else begin
              left_q    <= word_al;
              left_ok_q <= 1'b1;
            end
          end
          live_q      <= 1'b1;
          cur_right_q <= new_right;
          if (fmt == FMT_DSP) dsp_right_q <= ~dsp_right_q;
          pos_q <= POS_W'(1);
          if (start_i == 0) begin
            acc_q   <= {{(SW-1){1'b0}}, sd_i};
            nbits_q <= CNT_W'(1);
          end else begin
            acc_q   <= '0;
            nbits_q <= '0;
          end
        end else begin
          if (pos_q != '1) pos_q <= pos_q + 1'b1;
          if (take) begin
            acc_q   <= {acc_q[SW-2:0], sd_i};
            nbits_q <= nbits_q + 1'b1;
          end
        end
      end
    end
  end

  assign pair_stb_o = stb_q;
  assign left_o     = left_q;
  assign right_o    = right_q;

  // R9
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(pos_q) && $stable(acc_q));
endmodule

// File: rtl/pcm_rx_zero.sv
module pcm_rx_zero #(
  parameter int SW    = 24,
  parameter int LIMIT = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_i,
  input  logic [SW-1:0] sample_i,
  output logic          flag_o
);
  localparam int CNT_W = $clog2(LIMIT + 2);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (stb_i) begin
      if (sample_i != '0) cnt_q <= '0;
      else if (int'(cnt_q) <= LIMIT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign flag_o = int'(cnt_q) > LIMIT;

  // R7
  zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_i && (sample_i != '0) |=> !flag_o);
  // R7
  zero_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(stb_i) && ($past(sample_i) == '0));
endmodule

// File: rtl/pcm_rx_top.sv
module pcm_rx_top
  import pcm_rx_pkg::*;
#(
  parameter int ZERO_FRAMES = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_i,
  input  logic                lrclk_i,
  input  logic                sdata_i,
  input  logic [1:0]          fmt_i,
  input  logic [1:0]          rj_len_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [SAMPLE_W-1:0] out_left_o,
  output logic [SAMPLE_W-1:0] out_right_o,
  output logic                zero_left_o,
  output logic                zero_right_o
);
  localparam int NCH = 2;

  logic rise_s, fall_s, lr_s, sd_s, pair_stb;
  logic [SAMPLE_W-1:0] left_w, right_w;
  logic [SAMPLE_W-1:0] chan_w [NCH];
  logic [NCH-1:0]      zero_w;

  pcm_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .lrclk_i(lrclk_i), .sdata_i(sdata_i),
    .bclk_rise_o(rise_s), .bclk_fall_o(fall_s), .lr_o(lr_s), .sd_o(sd_s)
  );

  pcm_rx_deser #(.SW(SAMPLE_W), .HALF(HALF_SLOTS)) deser_i (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt_i), .rj_len_i(rj_len_i),
    .rise_i(rise_s), .fall_i(fall_s), .lr_i(lr_s), .sd_i(sd_s),
    .pair_stb_o(pair_stb), .left_o(left_w), .right_o(right_w)
  );

  assign chan_w[0] = left_w;
  assign chan_w[1] = right_w;

  for (genvar c = 0; c < NCH; c++) begin : g_zero
    pcm_rx_zero #(.SW(SAMPLE_W), .LIMIT(ZERO_FRAMES)) zero_i (
      .clk(clk), .rst_n(rst_n), .stb_i(pair_stb), .sample_i(chan_w[c]), .flag_o(zero_w[c])
    );
  end

  assign zero_left_o  = zero_w[0];
  assign zero_right_o = zero_w[1];

  // output holding stage: newest pair wins, held until accepted
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_left_o  <= '0;
      out_right_o <= '0;
    end else if (pair_stb) begin
      out_valid_o <= 1'b1;
      out_left_o  <= left_w;
      out_right_o <= right_w;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i && !pair_stb |=> out_valid_o && $stable(out_left_o) && $stable(out_right_o));
  // R6
  out_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && out_ready_i && !pair_stb |=> !out_valid_o);
  // R6
  pair_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb |-> $past(rise_s || fall_s));
endmodule

// File: tb/pcm_rx_top_tb_top.sv
`timescale 1ns/1ps
module pcm_rx_top_tb_top;
  localparam int H = 3;
  localparam int NV = 10;

  typedef struct packed {
    logic [1:0]  f;
    logic [1:0]  rl;
    logic [5:0]  w;
    logic [31:0] l;
    logic [31:0] r;
    logic [23:0] el;
    logic [23:0] er;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'b10, 2'b00, 6'd24, 32'h00123456, 32'h00FEDCBA, 24'h123456, 24'hFEDCBA}, // R1
    '{2'b10, 2'b00, 6'd16, 32'h00008001, 32'h00007FFE, 24'h800100, 24'h7FFE00}, // R5 short
    '{2'b10, 2'b00, 6'd32, 32'h12345678, 32'h9ABCDEF0, 24'h123456, 24'h9ABCDE}, // R5 long
    '{2'b01, 2'b00, 6'd24, 32'h005A5A5A, 32'h00A5A5A5, 24'h5A5A5A, 24'hA5A5A5}, // R2
    '{2'b01, 2'b00, 6'd18, 32'h00020001, 32'h0001FFFF, 24'h800040, 24'h7FFFC0}, // R2
    '{2'b00, 2'b00, 6'd24, 32'h00800001, 32'h007FFFFF, 24'h800001, 24'h7FFFFF}, // R3
    '{2'b00, 2'b01, 6'd20, 32'h00080000, 32'h0007FFFF, 24'hF80000, 24'h07FFFF}, // R3
    '{2'b00, 2'b10, 6'd16, 32'h00008001, 32'h00000123, 24'hFF8001, 24'h000123}, // R3
    '{2'b11, 2'b00, 6'd24, 32'h00C0FFEE, 32'h000F0F0F, 24'hC0FFEE, 24'h0F0F0F}, // R4
    '{2'b11, 2'b00, 6'd20, 32'h000ABCDE, 32'h00012345, 24'hABCDE0, 24'h123450}  // R4
  };

  logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b1, lrclk = 1'b0, sdata = 1'b0, out_ready = 1'b1;
  logic [1:0] fmt = 2'b10, rjl = 2'b00;
  logic out_valid, zero_l, zero_r;
  logic [23:0] out_left, out_right;

  always #4 clk = ~clk;

  pcm_rx_top #(.ZERO_FRAMES(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .lrclk_i(lrclk), .sdata_i(sdata),
    .fmt_i(fmt), .rj_len_i(rjl), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_left_o(out_left), .out_right_o(out_right),
    .zero_left_o(zero_l), .zero_right_o(zero_r)
  );

  int checks = 0, errors = 0, cap_n = 0;
  logic [23:0] cap_l = '0, cap_r = '0;

  always @(negedge clk) begin
    if (out_valid && out_ready) begin
      cap_l = out_left;
      cap_r = out_right;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic slot(input logic lr, input logic d, input bit dsp);
    @(negedge clk);
    lrclk = lr; sdata = d; bclk = dsp ? 1'b1 : 1'b0;
    repeat (H) @(negedge clk);
    bclk = dsp ? 1'b0 : 1'b1;
    repeat (H-1) @(negedge clk);
  endtask

  // one frame of 64 slots, with a bit-clock pause inside each half (R9)
  task automatic frame(input logic [1:0] f, input int w, input logic [31:0] l, input logic [31:0] r);
    for (int h = 0; h < 2; h++) begin
      for (int j = 0; j < 32; j++) begin
        logic [31:0] v;
        logic lr, d;
        int idx;
        v = (h == 0) ? l : r;
        idx = -1;
        case (f)
          2'b10: begin lr = (h == 0); if (j < w) idx = w - 1 - j; end
          2'b01: begin lr = (h == 1); if (j >= 1 && j - 1 < w) idx = w - j; end
          2'b00: begin lr = (h == 0); if (j >= 32 - w) idx = 31 - j; end
          default: begin lr = (j == 0); if (j >= 1 && j <= w) idx = w - j; end
        endcase
        d = (idx >= 0) ? v[idx] : 1'b0;
        slot(lr, d, f == 2'b11);
        if (j == 5) repeat (20) @(negedge clk);
      end
    end
  endtask

  task automatic start(input logic [1:0] f, input logic [1:0] rl, input logic rdy);
    @(negedge clk);
    rst_n = 1'b0; fmt = f; rjl = rl; out_ready = rdy;
    bclk = (f == 2'b11) ? 1'b0 : 1'b1;
    lrclk = (f == 2'b01) ? 1'b1 : 1'b0;
    sdata = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cap_n = 0;
  endtask

  function automatic string tag(input logic [1:0] f, input int w);
    string s;
    case (f)
      2'b00: s = "R3";
      2'b01: s = "R2";
      2'b10: s = "R1";
      default: s = "R4";
    endcase
    if (f != 2'b00 && w != 24) s = {s, "/R5"};
    return s;
  endfunction

  bit finished = 1'b0;

  task automatic summary();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R6 watchdog: actual hung expected completion");
      summary();
    end
  end

  initial begin
    // R8 reset state
    start(2'b10, 2'b00, 1'b1);
    chk(out_valid == 1'b0, "R8 valid after reset", 32'(out_valid), 0);
    chk(zero_l == 1'b0 && zero_r == 1'b0, "R8 zero flags after reset", {30'b0, zero_l, zero_r}, 0);

    // table walk: lead-in frame, vector frame, flush frame; R9 pause in each
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VECS[k];
      start(v.f, v.rl, 1'b1);
      frame(v.f, int'(v.w), 32'h0, 32'h0);
      frame(v.f, int'(v.w), v.l, v.r);
      frame(v.f, int'(v.w), 32'h0, 32'h0);
      repeat (10) @(negedge clk);
      chk(cap_n >= 1, {tag(v.f, int'(v.w)), " pair released"}, 32'(cap_n), 1);
      chk(cap_l == v.el, {tag(v.f, int'(v.w)), "/R9 left"}, 32'(cap_l), 32'(v.el));
      chk(cap_r == v.er, {tag(v.f, int'(v.w)), "/R9 right"}, 32'(cap_r), 32'(v.er));
    end

    // R6 back-pressure: newest pair overwrites while not ready
    start(2'b10, 2'b00, 1'b0);
    frame(2'b10, 24, 32'h0, 32'h0);
    frame(2'b10, 24, 32'h111111, 32'h222222);
    frame(2'b10, 24, 32'h333333, 32'h444444);
    frame(2'b10, 24, 32'h0, 32'h0);
    repeat (10) @(negedge clk);
    chk(out_valid == 1'b1, "R6 valid held without ready", 32'(out_valid), 1);
    chk(out_left == 24'h333333 && out_right == 24'h444444, "R6 newest pair held",
        {8'h0, out_left}, 32'h333333);
    out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 valid drops after accept", 32'(out_valid), 0);

    // R7 zero flag threshold (ZERO_FRAMES = 8)
    start(2'b10, 2'b00, 1'b1);
    for (int n = 0; n < 9; n++) frame(2'b10, 24, 32'h0, 32'h100);
    repeat (10) @(negedge clk);
    chk(zero_l == 1'b0, "R7 left flag low at threshold", 32'(zero_l), 0);
    frame(2'b10, 24, 32'h0, 32'h100);
    repeat (10) @(negedge clk);
    chk(zero_l == 1'b1, "R7 left flag high past threshold", 32'(zero_l), 1);
    chk(zero_r == 1'b0, "R7 right flag low with signal", 32'(zero_r), 0);
    frame(2'b10, 24, 32'h5, 32'h100);
    frame(2'b10, 24, 32'h0, 32'h100);
    repeat (10) @(negedge clk);
    chk(zero_l == 1'b0, "R7 left flag clears on nonzero", 32'(zero_l), 0);

    summary();
  end
endmodule